// File: doc/BRIEF.md
# Page Sector ECC Encoder and Corrector

This block adds single-bit error protection to a 2048-byte page payload that carries a 64-byte spare area. The payload is split into four 512-byte sectors. Page bytes arrive one at a time as a stream, each tagged with its page index. Data bytes use indices 0 to 2047 and spare bytes use 2048 to 2111. The block echoes the stream one cycle later.

In program mode the block builds a check code for each sector while the data bytes pass through. When the stream reaches a sector's slot in the spare area, the block substitutes that code for the incoming spare bytes. In read mode the block rebuilds each sector's code and compares it with the code stored in the slot. If they differ because of a single flipped bit, it emits one correction write that names the data-register byte and the bit to invert. If the difference cannot be corrected, it marks the page as failed.

The block also keeps a page verdict: clean, corrected or uncorrectable. An enable input turns all of this off, so every byte passes through unchanged.

Top module: `pageEccEngine`

## Requirements
- R1: While reset is held and afterwards until the first input, `outValid`, `corrValid` and `pageStatus` are 0.
- R2: In program mode with ECC on, each data byte (index < 2048) appears on `outData`/`outIndex` one cycle after it is presented, unchanged.
- R3: In program mode with ECC on, sector s owns spare indices 2080+4s to 2083+4s, and these output bytes are replaced by the sector's code. P is the XOR of (byteOffset*8+bit) over every set bit of the sector's 4096 bits, and O is the parity of those bits. Slot byte 0 = ~P[7:0]. Slot byte 1 = ~{3'b000, O, P[11:8]}. Slot bytes 2 and 3 = 8'hFF. All other spare bytes pass unchanged.
- R4: In read mode every byte, data and spare, passes to the output unchanged one cycle later.
- R5: Reading a page whose stored codes match its data produces no correction and leaves `pageStatus` at 2'b00.
- R6: In read mode, a single flipped data bit at offset b, bit k of sector s produces exactly one `corrValid` pulse, one cycle after index 2083+4s is presented. The pulse carries `corrIndex` = 512s+b and `corrMask` = 1<<k, and `pageStatus` becomes 2'b01 unless it is already 2'b10.
- R7: In read mode, a sector whose syndrome is nonzero but whose overall parity agrees (for example, two flipped bits) gives no correction and sets `pageStatus` to 2'b10. Status 2'b10 is not lowered by later corrected sectors of the same page.
- R8: A `pageStart` pulse clears `pageStatus` to 2'b00 on the next cycle.
- R9: With ECC off, program output equals input, including spare bytes, and reads raise no correction and leave `pageStatus` at 2'b00.
- R10: An erased page (all bytes 8'hFF, including the code slots) reads as clean.
- R11: `outValid` equals `inValid` delayed by one cycle, including idle gaps inside a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eccEnable | input | 1 | 1 enables code generation and checking |
| progMode | input | 1 | 1 selects program, 0 selects read |
| pageStart | input | 1 | Pulse that begins a page and clears the status |
| inValid | input | 1 | Byte present on this cycle |
| inIndex | input | 12 | Page index of the byte |
| inData | input | 8 | Byte value |
| outValid | output | 1 | Echoed byte present |
| outIndex | output | 12 | Index of the echoed byte |
| outData | output | 8 | Echoed byte; in program mode, code bytes in the code slots |
| corrValid | output | 1 | Correction write strobe |
| corrIndex | output | 12 | Data-register byte to correct |
| corrMask | output | 8 | One-hot bit to invert in that byte |
| pageStatus | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
Every result is registered once. The echoed byte is due the cycle after it is presented. A sector's correction and status update are due the cycle after its last code byte is presented. The status clear is due the cycle after `pageStart`. The bench reference model computes, at each falling edge, what the outputs must show at the next falling edge, and compares them there. Checks taken after each page confirm the exact corrected byte and bit against the flips that were injected.

// File: rtl/pageEccPkg.sv
package pageEccPkg;
  // Page geometry and code layout
  parameter int DATA_BYTES   = 2048;
  parameter int SPARE_BYTES  = 64;
  parameter int SECTOR_BYTES = 512;
  parameter int CODE_BASE    = 32;  // first spare offset holding codes
  parameter int CODE_BYTES   = 4;   // spare bytes per sector code

  localparam int SECTORS    = DATA_BYTES / SECTOR_BYTES;
  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int OFF_W      = $clog2(SECTOR_BYTES);
  localparam int SEC_W      = $clog2(SECTORS);
  localparam int SYN_W      = OFF_W + 3;
  localparam int CODE_W     = SYN_W + 1;
  localparam int SLOT_W     = $clog2(CODE_BYTES);

  typedef struct packed {
    logic              accum;       // data byte enters the sector code
    logic              sectorDone;  // last data byte of a sector
    logic [SEC_W-1:0]  dataSector;
    logic [OFF_W-1:0]  offset;
    logic              capture;     // read: stored code byte arrives
    logic              evalNow;     // read: final code byte of a sector
    logic              replace;     // program: output takes code byte
    logic [SEC_W-1:0]  slotSector;
    logic [SLOT_W-1:0] slotByte;
  } eccStrobes_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b10
  } pageStatus_e;
endpackage

// File: rtl/pageEccCtrl.sv
module pageEccCtrl
  import pageEccPkg::*;
(
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIndex,
  input  logic             progMode,
  input  logic             eccEnable,
  output eccStrobes_t      strb
);
  localparam int SLOT_LO = DATA_BYTES + CODE_BASE;
  localparam int SLOT_HI = SLOT_LO + CODE_BYTES * SECTORS;

  logic active, isData, inSlot;
  logic [SLOT_W+SEC_W-1:0] slotRel;

  always_comb begin
    active  = inValid && eccEnable;
    isData  = inIndex < IDX_W'(DATA_BYTES);
    inSlot  = (inIndex >= IDX_W'(SLOT_LO)) && (inIndex < IDX_W'(SLOT_HI));
    slotRel = (SLOT_W+SEC_W)'(inIndex - IDX_W'(SLOT_LO));

    strb            = '0;
    strb.dataSector = inIndex[OFF_W +: SEC_W];
    strb.offset     = inIndex[OFF_W-1:0];
    strb.slotSector = slotRel[SLOT_W +: SEC_W];
    strb.slotByte   = slotRel[SLOT_W-1:0];
    strb.accum      = active && isData;
    strb.sectorDone = active && isData && (&inIndex[OFF_W-1:0]);
    strb.capture    = active && !progMode && inSlot;
    strb.evalNow    = active && !progMode && inSlot && (&slotRel[SLOT_W-1:0]);
    strb.replace    = active && progMode && inSlot;
  end
endmodule

// File: rtl/pageEccDatapath.sv
module pageEccDatapath
  import pageEccPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pageStart,
  input  eccStrobes_t      strb,
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIndex,
  input  logic [7:0]       inData,
  output logic             outValid,
  output logic [IDX_W-1:0] outIndex,
  output logic [7:0]       outData,
  output logic             corrValid,
  output logic [IDX_W-1:0] corrIndex,
  output logic [7:0]       corrMask,
  output logic [1:0]       pageStatus
);
  // Contribution of one byte to a sector code: {parity, position XOR}
  function automatic logic [CODE_W-1:0] byteContrib(logic [OFF_W-1:0] off, logic [7:0] d);
    logic [2:0] low;
    logic       par;
    low = '0;
    par = ^d;
    for (int k = 0; k < 8; k++)
      if (d[k]) low = low ^ 3'(k);
    return {par, (par ? off : {OFF_W{1'b0}}), low};
  endfunction

  logic [CODE_W-1:0]           accCode, accNext;
  logic [CODE_W-1:0]           codeReg [SECTORS];
  logic [8*(CODE_BYTES-1)-1:0] capBytes;
  logic [CODE_W-1:0]           storedCode, diff;
  logic [SYN_W-1:0]            syn;
  logic                        synInRange;
  logic [8*CODE_BYTES-1:0]     codePad;
  logic [7:0]                  replByte;
  pageStatus_e                 verdict, statusQ;

  always_comb begin
    accNext    = accCode ^ byteContrib(strb.offset, inData);
    storedCode = CODE_W'(~{inData, capBytes});
    diff       = storedCode ^ codeReg[strb.slotSector];
    syn        = diff[SYN_W-1:0];
    codePad    = (8*CODE_BYTES)'(codeReg[strb.slotSector]);
    replByte   = ~codePad[8*strb.slotByte +: 8];
  end

  // A syndrome can only leave the sector when the sector is not a power of two
  generate
    if (SECTOR_BYTES * 8 < 2 ** SYN_W) begin : g_rangeCheck
      assign synInRange = syn < SYN_W'(SECTOR_BYTES * 8);
    end else begin : g_fullRange
      assign synInRange = 1'b1;
    end
  endgenerate

  always_comb begin
    if (diff == '0)                         verdict = ST_CLEAN;
    else if (diff[CODE_W-1] && synInRange)  verdict = ST_FIXED;
    else                                    verdict = ST_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCode  <= '0;
      capBytes <= '0;
      for (int i = 0; i < SECTORS; i++) codeReg[i] <= '0;
    end else begin
      if (pageStart)        accCode <= '0;
      else if (strb.accum)  accCode <= strb.sectorDone ? '0 : accNext;
      if (strb.sectorDone)  codeReg[strb.dataSector] <= accNext;
      if (strb.capture && !strb.evalNow)
        capBytes[8*strb.slotByte +: 8] <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outIndex  <= '0;
      outData   <= '0;
      corrValid <= 1'b0;
      corrIndex <= '0;
      corrMask  <= '0;
      statusQ   <= ST_CLEAN;
    end else begin
      outValid  <= inValid;
      outIndex  <= inIndex;
      outData   <= strb.replace ? replByte : inData;
      corrValid <= strb.evalNow && (verdict == ST_FIXED);
      corrIndex <= IDX_W'({strb.slotSector, syn[SYN_W-1:3]});
      corrMask  <= 8'(1) << syn[2:0];
      if (pageStart)
        statusQ <= ST_CLEAN;
      else if (strb.evalNow) begin
        if (verdict == ST_FAIL || statusQ == ST_FAIL) statusQ <= ST_FAIL;
        else if (verdict == ST_FIXED)                 statusQ <= ST_FIXED;
      end
    end
  end

  assign pageStatus = statusQ;

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pageStatus != 2'b11); // R7
  AST_CORR_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    corrValid |-> $countones(corrMask) == 1); // R6
  AST_CORR_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    corrValid |-> corrIndex < IDX_W'(DATA_BYTES)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(pageStart) && $past(pageStatus) == 2'b10) |-> pageStatus == 2'b10); // R7
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(pageStart)) |-> pageStatus == 2'b00); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid)); // R11
endmodule

// File: rtl/pageEccEngine.sv
module pageEccEngine
  import pageEccPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             eccEnable,
  input  logic             progMode,
  input  logic             pageStart,
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIndex,
  input  logic [7:0]       inData,
  output logic             outValid,
  output logic [IDX_W-1:0] outIndex,
  output logic [7:0]       outData,
  output logic             corrValid,
  output logic [IDX_W-1:0] corrIndex,
  output logic [7:0]       corrMask,
  output logic [1:0]       pageStatus
);
  eccStrobes_t strb;

  pageEccCtrl u_ctrl (
    .inValid   (inValid),
    .inIndex   (inIndex),
    .progMode  (progMode),
    .eccEnable (eccEnable),
    .strb      (strb)
  );

  pageEccDatapath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .pageStart  (pageStart),
    .strb       (strb),
    .inValid    (inValid),
    .inIndex    (inIndex),
    .inData     (inData),
    .outValid   (outValid),
    .outIndex   (outIndex),
    .outData    (outData),
    .corrValid  (corrValid),
    .corrIndex  (corrIndex),
    .corrMask   (corrMask),
    .pageStatus (pageStatus)
  );

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(eccEnable)) |-> !corrValid); // R9
endmodule

// File: tb/pageEccEngine_bench.sv
module pageEccEngine_bench;
  logic        clk = 1'b0;
  logic        rstN, eccEnable, progMode, pageStart, inValid;
  logic [11:0] inIndex;
  logic [7:0]  inData;
  logic        outValid, corrValid;
  logic [11:0] outIndex, corrIndex;
  logic [7:0]  outData, corrMask;
  logic [1:0]  pageStatus;

  always #2 clk = ~clk;

  pageEccEngine u_pageEccEngine (
    .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .progMode(progMode),
    .pageStart(pageStart), .inValid(inValid), .inIndex(inIndex), .inData(inData),
    .outValid(outValid), .outIndex(outIndex), .outData(outData),
    .corrValid(corrValid), .corrIndex(corrIndex), .corrMask(corrMask),
    .pageStatus(pageStatus)
  );

  int errs = 0, checks = 0;
  logic [7:0] img  [2112];
  logic [7:0] got  [2112];
  logic [7:0] gold [2112];

  // Expected outputs for the next falling edge
  bit         eOV, eCV;
  int         eOI, eCI;
  logic [7:0] eOD, eCM;
  logic [1:0] eSt;
  string      tag;
  int         corrSeen, lastCorrIdx;
  logic [7:0] lastCorrMask;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] refCode(int s);
    logic [11:0] p = '0;
    bit o = 0;
    for (int b = 0; b < 512; b++)
      for (int k = 0; k < 8; k++)
        if (img[s*512+b][k]) begin
          p = p ^ 12'(b*8+k);
          o = ~o;
        end
    return {o, p};
  endfunction

  task automatic compareNow();
    check(outValid == eOV, "R11", "outValid", outValid, eOV);
    if (eOV) begin
      check(outIndex == 12'(eOI), tag, "outIndex", outIndex, eOI);
      check(outData == eOD, tag, "outData", outData, eOD);
    end
    if (outValid) got[outIndex] = outData;
    check(corrValid == eCV, "R6", "corrValid", corrValid, eCV);
    if (corrValid) begin
      corrSeen++;
      lastCorrIdx  = corrIndex;
      lastCorrMask = corrMask;
      if (eCV) begin
        check(corrIndex == 12'(eCI), "R6", "corrIndex", corrIndex, eCI);
        check(corrMask == eCM, "R6", "corrMask", corrMask, eCM);
      end
    end
    check(pageStatus == eSt, "R7", "pageStatus", pageStatus, eSt);
  endtask

  task automatic sendByte(input int i, input bit prog, input bit en);
    logic [12:0] c;
    logic [7:0]  b0, b1;
    logic [11:0] sp, syn;
    bit          so, od;
    int          s, k;
    @(negedge clk);
    compareNow();
    pageStart = 0; inValid = 1; inIndex = 12'(i); inData = img[i];
    eOV = 1; eOI = i; eOD = img[i]; eCV = 0;
    if (en && i >= 2080 && i < 2096) begin
      s = (i - 2080) / 4;
      k = (i - 2080) % 4;
      c = refCode(s);
      if (prog) begin
        if (k == 0)      eOD = ~c[7:0];
        else if (k == 1) eOD = ~{3'b000, c[12:8]};
        else             eOD = 8'hFF;
      end else if (k == 3) begin
        b0 = img[2080+4*s]; b1 = img[2081+4*s];
        sp = ~{b1[3:0], b0}; so = ~b1[4];
        syn = sp ^ c[11:0]; od = so ^ c[12];
        if (syn == 0 && !od) begin
        end else if (od) begin
          eCV = 1; eCI = s*512 + int'(syn >> 3); eCM = 8'(1) << syn[2:0];
          if (eSt != 2'b10) eSt = 2'b01;
        end else eSt = 2'b10;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    compareNow();
    pageStart = 0; inValid = 0; eOV = 0; eCV = 0;
  endtask

  task automatic startPage(input bit prog, input bit en);
    @(negedge clk);
    compareNow();
    progMode = prog; eccEnable = en; pageStart = 1; inValid = 0;
    eOV = 0; eCV = 0; eSt = 2'b00; corrSeen = 0;
  endtask

  task automatic runPage(input bit prog, input bit en);
    startPage(prog, en);
    for (int i = 0; i < 2112; i++) begin
      sendByte(i, prog, en);
      if (i % 300 == 7) idle();
    end
    idle(); idle();
  endtask

  task automatic loadGold();
    for (int i = 0; i < 2112; i++) img[i] = gold[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rstN = 0; eccEnable = 0; progMode = 0; pageStart = 0;
    inValid = 0; inIndex = '0; inData = '0;
    eOV = 0; eCV = 0; eSt = 2'b00; tag = "R1"; corrSeen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held by reset
    check(outValid == 0, "R1", "outValid", outValid, 0);
    check(corrValid == 0, "R1", "corrValid", corrValid, 0);
    check(pageStatus == 0, "R1", "pageStatus", pageStatus, 0);
    rstN = 1;
    idle();

    // R2 R3: program with codes inserted
    for (int i = 0; i < 2048; i++) img[i] = 8'((i*37) ^ (i >> 3) ^ 8'h5A);
    for (int i = 2048; i < 2112; i++) img[i] = 8'hFF;
    tag = "R3";
    runPage(1, 1);
    for (int i = 0; i < 2112; i++) gold[i] = got[i];
    check(gold[100] == img[100], "R2", "data byte", gold[100], img[100]);
    check(gold[2100] == 8'hFF, "R3", "non-slot spare", gold[2100], 8'hFF);

    // R4 R5: clean read
    loadGold(); tag = "R4";
    runPage(0, 1);
    check(corrSeen == 0, "R5", "corrections", corrSeen, 0);
    check(pageStatus == 2'b00, "R5", "status", pageStatus, 0);

    // R6: single flip in sector 1
    loadGold(); img[612] ^= 8'h20;
    runPage(0, 1);
    check(corrSeen == 1, "R6", "corrections", corrSeen, 1);
    check(lastCorrIdx == 612, "R6", "index", lastCorrIdx, 612);
    check(lastCorrMask == 8'h20, "R6", "mask", lastCorrMask, 8'h20);
    check(pageStatus == 2'b01, "R6", "status", pageStatus, 1);

    // R6: flips at the first and the last bit positions
    loadGold(); img[0] ^= 8'h01; img[2047] ^= 8'h80;
    runPage(0, 1);
    check(corrSeen == 2, "R6", "corrections", corrSeen, 2);
    check(lastCorrIdx == 2047, "R6", "index", lastCorrIdx, 2047);
    check(lastCorrMask == 8'h80, "R6", "mask", lastCorrMask, 8'h80);

    // R7: double flip in sector 2 between two single flips
    loadGold(); img[10] ^= 8'h04; img[1029] ^= 8'h02; img[1324] ^= 8'h40; img[1600] ^= 8'h08;
    runPage(0, 1);
    check(corrSeen == 2, "R7", "corrections", corrSeen, 2);
    check(pageStatus == 2'b10, "R7", "status", pageStatus, 2);

    // R8: page start clears the verdict
    startPage(0, 1); idle();
    check(pageStatus == 2'b00, "R8", "status", pageStatus, 0);

    // R10: erased page
    for (int i = 0; i < 2112; i++) img[i] = 8'hFF;
    tag = "R10";
    runPage(0, 1);
    check(corrSeen == 0, "R10", "corrections", corrSeen, 0);
    check(pageStatus == 2'b00, "R10", "status", pageStatus, 0);

    // R9: bypass in both directions
    for (int i = 0; i < 2048; i++) img[i] = 8'(i ^ 8'hC3);
    for (int i = 2048; i < 2112; i++) img[i] = 8'(i);
    tag = "R9";
    runPage(1, 0);
    check(got[2080] == 8'(2080), "R9", "slot byte", got[2080], 8'(2080));
    loadGold(); img[700] ^= 8'h10;
    runPage(0, 0);
    check(corrSeen == 0, "R9", "corrections", corrSeen, 0);
    check(pageStatus == 2'b00, "R9", "status", pageStatus, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule